// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns the row and column strobes of an asynchronous DRAM whenever the memory needs refreshing. After reset it keeps the strobes idle for a start-up delay. It then runs a fixed series of warm-up refresh cycles and raises `ready_o`. From then on an interval timer schedules one refresh for each slot in the refresh period. Every refresh is a CAS-before-RAS cycle, so the memory supplies the row address itself. Write-enable is held high throughout, so the memory's test mode can never be entered by accident.

The block shares the bus with an access sequencer. When refreshes are owed it raises a request. It starts a cycle only in a clock where the sequencer returns a grant. Refreshes that cannot be granted right away pile up in a saturating debt counter. Once the debt reaches a threshold, an urgency flag tells the arbiter to favour refresh. While the block drives the strobes, `ref_active_o` tells the sequencer to release them. A level request puts the memory into self-refresh. RAS is held low for at least the minimum self-refresh time and for as long as the request stays high. After exit, a long precharge is enforced, the debt is cleared and the interval timer restarts.

Top module: `dram_ref_sched`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, `ready_o` and `ref_req_o` are 0, and `debt_o` is 0.
- R2: After reset is released, `cas_n_o` and `ras_n_o` stay at 1 for at least STARTUP_US*CLK_MHZ clock cycles.
- R3: Exactly INIT_REFS refresh cycles (falling edges of `cas_n_o`) occur before `ready_o` rises. Once high, `ready_o` stays high until reset.
- R4: In every cycle the block drives, `cas_n_o` falls at least ceil(T_CSR_NS*CLK_MHZ/1000) cycles before `ras_n_o` falls. `cas_n_o` stays 0 in every cycle in which `ras_n_o` is 0.
- R5: In a normal refresh, `ras_n_o` stays low for at least ceil(T_RAS_NS*CLK_MHZ/1000) cycles. Both strobes are then high together for at least ceil(T_RP_NS*CLK_MHZ/1000) cycles before `cas_n_o` falls again.
- R6: `we_n_o` is 1 in every cycle.
- R7: The refresh interval is I = PERIOD_US*CLK_MHZ/ROWS cycles. PERIOD_US is PERIOD_STD_US, or PERIOD_LP_US when LOW_POWER is 1. The debt goes up by one I cycles after `ready_o` rises, I cycles after `self_ref_o` falls, and every I cycles after that.
- R8: `debt_o` saturates at DEBT_MAX. `ref_urgent_o` is 1 exactly when `debt_o` >= URGENT_THR.
- R9: `ref_req_o` is 1 when ready, when no cycle is in progress, and when the debt is nonzero or self-refresh is requested. A cycle starts in a clock where both `ref_req_o` and `ref_gnt_i` are 1. The debt drops by one in the cycle in which `ras_n_o` rises at the end of a normal refresh. An interval tick that lands on that same cycle leaves the debt unchanged.
- R10: `ref_active_o` is 1 whenever `ras_n_o` or `cas_n_o` is 0, and throughout start-up and initialization.
- R11: A granted request with `self_ref_req_i` high enters self-refresh. `ras_n_o` then stays low for at least T_RASS_US*CLK_MHZ cycles and for as long as `self_ref_req_i` is 1. `self_ref_o` is 1 from entry through the exit precharge.
- R12: After self-refresh, both strobes stay high for at least ceil(T_RPS_NS*CLK_MHZ/1000) cycles before the next `cas_n_o` fall. `debt_o` reads 0 in the cycle in which `self_ref_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt_i | input | 1 | Bus grant from the access sequencer |
| self_ref_req_i | input | 1 | Level request to enter or stay in self-refresh |
| ref_req_o | output | 1 | Bus request for a refresh or self-refresh entry |
| ref_urgent_o | output | 1 | Debt has reached the urgency threshold |
| ref_active_o | output | 1 | Block owns the strobes; sequencer must release them |
| ready_o | output | 1 | Start-up and warm-up refreshes are complete |
| self_ref_o | output | 1 | Self-refresh in progress, including its exit precharge |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held high |
| debt_o | output | $clog2(DEBT_MAX+1) | Refreshes owed |

## Verification
Two events can land in the same clock and both act on the debt counter: the interval timer adding a refresh and a finishing refresh removing one. The bench provokes this by granting the bus at random, with changing probability, across many intervals. Completions therefore drift through every phase of the tick. The bench also runs a cycle-by-cycle model of the debt, built from tick times it derives from the `ready_o` and `self_ref_o` edges and from the RAS rising edges it observes. In every cycle it compares `debt_o` and `ref_urgent_o` with that model, so a coincident tick and completion must leave the count unchanged.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CAS_LEAD,
      SQ_RAS_LOW,
      SQ_PRECH,
      SQ_SELF,
      SQ_SELF_PRECH
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_WAIT,
      PH_INIT,
      PH_RUN
   } phase_t;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int ns_to_cyc(input int ns, input int mhz);
      int c;
      c = (ns * mhz + 999) / 1000;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_ref_init.sv
module dram_ref_init
   import dram_ref_pkg::*;
#(
   parameter int STARTUP_CYC = 20000,
   parameter int INIT_REFS   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seq_idle_i,
   input  logic seq_done_i,
   output logic start_o,
   output logic wait_o,
   output logic ready_o
);
   localparam int SW = $clog2(STARTUP_CYC + 1);
   localparam int IW = $clog2(INIT_REFS + 1);

   phase_t          phase;
   logic [SW-1:0]   wait_cnt;
   logic [IW-1:0]   init_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_WAIT;
         wait_cnt <= '0;
         init_cnt <= '0;
      end else begin
         unique case (phase)
            PH_WAIT: begin
               if (wait_cnt == SW'(STARTUP_CYC - 1)) phase <= PH_INIT;
               else                                  wait_cnt <= wait_cnt + SW'(1);
            end
            PH_INIT: begin
               if (seq_done_i) init_cnt <= init_cnt + IW'(1);
               if (init_cnt == IW'(INIT_REFS) && seq_idle_i) phase <= PH_RUN;
            end
            default: phase <= PH_RUN;
         endcase
      end
   end

   assign start_o = (phase == PH_INIT) && seq_idle_i && (init_cnt < IW'(INIT_REFS));
   assign wait_o  = (phase == PH_WAIT);
   assign ready_o = (phase == PH_RUN);

   // R3
   init_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(init_cnt) == IW'(INIT_REFS));

endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
   parameter int INT_STD   = 1562,
   parameter int INT_LP    = 3125,
   parameter bit LOW_POWER = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int IMAX = (INT_STD > INT_LP) ? INT_STD : INT_LP;
   localparam int IW   = $clog2(IMAX + 1);

   logic [IW-1:0] cnt;
   logic [IW-1:0] lim;

   generate
      if (LOW_POWER) begin : g_long_period
         assign lim = IW'(INT_LP - 1);
      end else begin : g_std_period
         assign lim = IW'(INT_STD - 1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i) cnt <= '0;
      else if (cnt == lim)  cnt <= '0;
      else                  cnt <= cnt + IW'(1);
   end

   assign tick_o = run_i && (cnt == lim);

   // R7
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

endmodule

// File: rtl/dram_ref_debt.sv
module dram_ref_debt #(
   parameter int DEBT_MAX   = 8,
   parameter int URGENT_THR = 4,
   parameter int W          = $clog2(DEBT_MAX + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         dec_i,
   input  logic         clr_i,
   output logic [W-1:0] debt_o,
   output logic         urgent_o
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         debt_o <= '0;
      end else if (tick_i && !dec_i) begin
         if (debt_o != W'(DEBT_MAX)) debt_o <= debt_o + W'(1);
      end else if (dec_i && !tick_i) begin
         if (debt_o != '0) debt_o <= debt_o - W'(1);
      end
   end

   assign urgent_o = (debt_o >= W'(URGENT_THR));

   // R8
   debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      debt_o <= W'(DEBT_MAX));

   // R9
   debt_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && dec_i && !clr_i) |=> $stable(debt_o));

   // R9
   debt_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i |-> debt_o != '0);

endmodule

// File: rtl/dram_ref_strobe.sv
module dram_ref_strobe
   import dram_ref_pkg::*;
#(
   parameter int CSR_CYC  = 1,
   parameter int RAS_CYC  = 5,
   parameter int RP_CYC   = 3,
   parameter int RASS_CYC = 10000,
   parameter int RPS_CYC  = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic self_i,
   input  logic self_req_i,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic idle_o,
   output logic done_o,
   output logic self_o,
   output logic self_done_o
);
   localparam int MAXC = max2(max2(max2(CSR_CYC, RAS_CYC), max2(RP_CYC, RPS_CYC)), RASS_CYC);
   localparam int CW   = $clog2(MAXC + 1);

   seq_state_t    state, nxt;
   logic [CW-1:0] cnt, cnt_nxt;
   logic          self_q;

   always_comb begin
      nxt         = state;
      cnt_nxt     = (cnt == '0) ? '0 : cnt - CW'(1);
      done_o      = 1'b0;
      self_done_o = 1'b0;
      unique case (state)
         SQ_IDLE: begin
            if (start_i) begin
               nxt     = SQ_CAS_LEAD;
               cnt_nxt = CW'(CSR_CYC - 1);
            end
         end
         SQ_CAS_LEAD: begin
            if (cnt == '0) begin
               if (self_q) begin
                  nxt     = SQ_SELF;
                  cnt_nxt = CW'(RASS_CYC - 1);
               end else begin
                  nxt     = SQ_RAS_LOW;
                  cnt_nxt = CW'(RAS_CYC - 1);
               end
            end
         end
         SQ_RAS_LOW: begin
            if (cnt == '0) begin
               nxt     = SQ_PRECH;
               cnt_nxt = CW'(RP_CYC - 1);
               done_o  = 1'b1;
            end
         end
         SQ_PRECH: begin
            if (cnt == '0) nxt = SQ_IDLE;
         end
         SQ_SELF: begin
            if (cnt == '0 && !self_req_i) begin
               nxt     = SQ_SELF_PRECH;
               cnt_nxt = CW'(RPS_CYC - 1);
            end
         end
         SQ_SELF_PRECH: begin
            if (cnt == '0) begin
               nxt         = SQ_IDLE;
               self_done_o = 1'b1;
            end
         end
         default: nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         cnt     <= '0;
         self_q  <= 1'b0;
         ras_n_o <= 1'b1;
         cas_n_o <= 1'b1;
      end else begin
         state   <= nxt;
         cnt     <= cnt_nxt;
         ras_n_o <= !(nxt == SQ_RAS_LOW || nxt == SQ_SELF);
         cas_n_o <= !(nxt == SQ_CAS_LEAD || nxt == SQ_RAS_LOW || nxt == SQ_SELF);
         if (state == SQ_IDLE && start_i) self_q <= self_i;
         else if (self_done_o)            self_q <= 1'b0;
      end
   end

   assign idle_o = (state == SQ_IDLE);
   assign self_o = self_q;

   // checker state: run lengths of strobe levels, saturating
   logic [CW-1:0] hi_run, lo_run;
   logic          after_self;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run     <= CW'(MAXC);
         lo_run     <= '0;
         after_self <= 1'b0;
      end else begin
         if (ras_n_o && cas_n_o) hi_run <= (hi_run == CW'(MAXC)) ? hi_run : hi_run + CW'(1);
         else                    hi_run <= '0;
         if (!ras_n_o)           lo_run <= (lo_run == CW'(MAXC)) ? lo_run : lo_run + CW'(1);
         else                    lo_run <= '0;
         if (self_done_o)               after_self <= 1'b1;
         else if ($fell(cas_n_o))       after_self <= 1'b0;
      end
   end

   // R4
   cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> (!cas_n_o && $past(cas_n_o) == 1'b0));

   // R4
   cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n_o |-> !cas_n_o);

   // R5
   ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ras_n_o) && !self_q) |-> lo_run >= CW'(RAS_CYC));

   // R5
   prech_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n_o) |-> hi_run >= CW'(RP_CYC));

   // R12
   self_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n_o) && after_self) |-> hi_run >= CW'(RPS_CYC));

   // R11
   self_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ras_n_o) && self_q) |-> lo_run >= CW'(RASS_CYC));

endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched
   import dram_ref_pkg::*;
#(
   parameter int CLK_MHZ       = 100,
   parameter int STARTUP_US    = 200,
   parameter int INIT_REFS     = 8,
   parameter int ROWS          = 4096,
   parameter int PERIOD_STD_US = 64000,
   parameter int PERIOD_LP_US  = 128000,
   parameter bit LOW_POWER     = 1'b0,
   parameter int DEBT_MAX      = 8,
   parameter int URGENT_THR    = 4,
   parameter int T_CSR_NS      = 10,
   parameter int T_CHR_NS      = 10,
   parameter int T_RAS_NS      = 50,
   parameter int T_RP_NS       = 30,
   parameter int T_RASS_US     = 100,
   parameter int T_RPS_NS      = 90
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            ref_gnt_i,
   input  logic                            self_ref_req_i,
   output logic                            ref_req_o,
   output logic                            ref_urgent_o,
   output logic                            ref_active_o,
   output logic                            ready_o,
   output logic                            self_ref_o,
   output logic                            ras_n_o,
   output logic                            cas_n_o,
   output logic                            we_n_o,
   output logic [$clog2(DEBT_MAX+1)-1:0]   debt_o
);
   localparam int DEBT_W      = $clog2(DEBT_MAX + 1);
   localparam int STARTUP_CYC = STARTUP_US * CLK_MHZ;
   localparam int INT_STD     = PERIOD_STD_US * CLK_MHZ / ROWS;
   localparam int INT_LP      = PERIOD_LP_US * CLK_MHZ / ROWS;
   localparam int CSR_CYC     = ns_to_cyc(T_CSR_NS, CLK_MHZ);
   localparam int CHR_CYC     = ns_to_cyc(T_CHR_NS, CLK_MHZ);
   localparam int RAS_CYC     = ns_to_cyc(T_RAS_NS, CLK_MHZ);
   localparam int RP_CYC      = ns_to_cyc(T_RP_NS, CLK_MHZ);
   localparam int RPS_CYC     = ns_to_cyc(T_RPS_NS, CLK_MHZ);
   localparam int RASS_CYC    = T_RASS_US * CLK_MHZ;

   initial begin
      assert (INIT_REFS >= 1)               else $error("INIT_REFS must be at least one");
      assert (INT_STD >= 2 && INT_LP >= 2)  else $error("refresh interval too short");
      assert (RAS_CYC >= CHR_CYC)           else $error("RAS width below CAS hold");
      assert (URGENT_THR <= DEBT_MAX)       else $error("urgency threshold above debt limit");
      assert (RASS_CYC >= RAS_CYC)          else $error("self-refresh width too short");
   end

   logic init_start, init_wait;
   logic seq_start, seq_idle, seq_done, seq_self, seq_self_done;
   logic tick;

   dram_ref_init #(
      .STARTUP_CYC (STARTUP_CYC),
      .INIT_REFS   (INIT_REFS)
   ) init_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_idle_i (seq_idle),
      .seq_done_i (seq_done),
      .start_o    (init_start),
      .wait_o     (init_wait),
      .ready_o    (ready_o)
   );

   dram_ref_timer #(
      .INT_STD   (INT_STD),
      .INT_LP    (INT_LP),
      .LOW_POWER (LOW_POWER)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (ready_o && !seq_self),
      .tick_o (tick)
   );

   dram_ref_debt #(
      .DEBT_MAX   (DEBT_MAX),
      .URGENT_THR (URGENT_THR),
      .W          (DEBT_W)
   ) debt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .dec_i    (seq_done && ready_o),
      .clr_i    (seq_self_done),
      .debt_o   (debt_o),
      .urgent_o (ref_urgent_o)
   );

   assign ref_req_o = ready_o && seq_idle && ((debt_o != '0) || self_ref_req_i);
   assign seq_start = ready_o ? (ref_req_o && ref_gnt_i) : init_start;

   dram_ref_strobe #(
      .CSR_CYC  (CSR_CYC),
      .RAS_CYC  (RAS_CYC),
      .RP_CYC   (RP_CYC),
      .RASS_CYC (RASS_CYC),
      .RPS_CYC  (RPS_CYC)
   ) strobe_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (seq_start),
      .self_i      (ready_o && self_ref_req_i),
      .self_req_i  (self_ref_req_i),
      .ras_n_o     (ras_n_o),
      .cas_n_o     (cas_n_o),
      .idle_o      (seq_idle),
      .done_o      (seq_done),
      .self_o      (seq_self),
      .self_done_o (seq_self_done)
   );

   assign self_ref_o   = seq_self;
   assign ref_active_o = !ready_o || !seq_idle;
   assign we_n_o       = 1'b1;

   // R2
   quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_wait |-> (ras_n_o && cas_n_o));

   // R10
   own_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n_o || !cas_n_o) |-> ref_active_o);

   // R3
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> ready_o);

   // R11
   self_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (self_ref_o && self_ref_req_i && !ras_n_o) |=> !ras_n_o);

endmodule

// File: tb/dram_ref_sched_tb.sv
module dram_ref_sched_tb_top;

   localparam int MHZ   = 100;
   localparam int ST_US = 2;
   localparam int IREFS = 8;
   localparam int DMAX  = 8;
   localparam int UTHR  = 4;
   localparam int IVL   = 64 * MHZ / 64;
   localparam int STCYC = ST_US * MHZ;
   localparam int CSRC  = 1;
   localparam int RASC  = 5;
   localparam int RPC   = 3;
   localparam int RPSC  = 9;
   localparam int RASSC = 1 * MHZ;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gnt = 1'b0;
   logic sreq = 1'b0;
   logic req, urg, act, rdy, sref, ras_n, cas_n, we_n;
   logic [3:0] debt;

   always #5 clk = ~clk;

   dram_ref_sched #(
      .CLK_MHZ(MHZ), .STARTUP_US(ST_US), .INIT_REFS(IREFS), .ROWS(64),
      .PERIOD_STD_US(64), .PERIOD_LP_US(128), .LOW_POWER(1'b0),
      .DEBT_MAX(DMAX), .URGENT_THR(UTHR), .T_CSR_NS(10), .T_CHR_NS(10),
      .T_RAS_NS(50), .T_RP_NS(30), .T_RASS_US(1), .T_RPS_NS(90)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_gnt_i(gnt), .self_ref_req_i(sreq),
      .ref_req_o(req), .ref_urgent_o(urg), .ref_active_o(act), .ready_o(rdy),
      .self_ref_o(sref), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
      .debt_o(debt)
   );

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string rq, input string what,
                        input int act_v, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act_v, exp_v);
      end
   endtask

   function automatic int sat_inc(input int v);
      return (v >= DMAX) ? DMAX : v + 1;
   endfunction

   function automatic bit tick_due(input int c, input int t0);
      return (c >= t0) && (((c - t0) % IVL) == 0);
   endfunction

   // monitor state
   bit ras_p = 1, cas_p = 1, rdy_p = 0, sref_p = 0, need_rps = 0;
   int hi_run = 1000, cas_fall_cyc = 0, ras_fall_cyc = 0;
   int n_cas_fall = 0, n_ras_fall = 0, first_fall = -1;
   int v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r10 = 0, v_r12 = 0;
   int t_ready = 0, t0 = 0, t_exit = 0, self_len = 0;
   int model = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit inc, dec;
         if (we_n !== 1'b1) v_r6++;
         if ((!ras_n || !cas_n) && !act) v_r10++;
         if (!rdy && !act) v_r10++;
         if (cas_p && !cas_n) begin
            n_cas_fall++;
            if (first_fall < 0) first_fall = cyc;
            cas_fall_cyc = cyc;
            if (hi_run < RPC) v_r5++;
            if (need_rps && hi_run < RPSC) v_r12++;
            need_rps = 0;
         end
         if (ras_p && !ras_n) begin
            n_ras_fall++;
            ras_fall_cyc = cyc;
            if (cas_n || (cyc - cas_fall_cyc) < CSRC) v_r4++;
         end
         if (!ras_n && cas_n) v_r4++;
         if (!ras_p && ras_n) begin
            if (sref) self_len = cyc - ras_fall_cyc;
            else if ((cyc - ras_fall_cyc) < RASC) v_r5++;
         end
         if (ras_n && cas_n) hi_run++; else hi_run = 0;

         // debt reference model
         inc = 0; dec = 0;
         if (!rdy_p && rdy) begin
            t_ready = cyc;
            t0 = cyc + IVL;
         end
         if (sref_p && !sref) begin
            model = 0;
            t_exit = cyc;
            t0 = cyc + IVL;
            need_rps = 1;
         end else if (rdy) begin
            inc = tick_due(cyc, t0) && !sref_p;
            dec = !ras_p && ras_n && !sref;
            if (inc && !dec) model = sat_inc(model);
            else if (dec && !inc) model = model - 1;
         end
         check(int'(debt) == model, "R9", "debt vs model", int'(debt), model);
         check(urg == (model >= UTHR), "R8", "urgent flag", int'(urg), int'(model >= UTHR));
         ras_p = ras_n; cas_p = cas_n; rdy_p = rdy; sref_p = sref;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_cyc(input int c);
      while (cyc < c) step();
   endtask

   initial begin
      int rel;
      void'($urandom(32'd5150));
      repeat (4) step();
      // R1 during reset
      check(ras_n && cas_n && we_n, "R1", "strobes in reset", int'({ras_n, cas_n, we_n}), 7);
      check(!rdy && !req && debt == 0, "R1", "ready/req/debt in reset", int'({rdy, req}), 0);
      rst_n = 1'b1;
      rel = cyc;
      step();
      check(ras_n && cas_n && !rdy && !req && debt == 0, "R1", "first cycle after reset",
            int'({ras_n, cas_n, rdy, req}), 12);

      while (!rdy) step();
      check(n_cas_fall == IREFS, "R3", "warm-up refresh count", n_cas_fall, IREFS);
      check(first_fall - rel >= STCYC, "R2", "start-up quiet cycles", first_fall - rel, STCYC);
      check(!req, "R9", "no request with zero debt", int'(req), 0);

      // postponed refreshes accumulate
      wait_cyc(t_ready + 2 * IVL + 50);
      check(debt == 2, "R7", "debt after two intervals", int'(debt), 2);
      check(req, "R9", "request with debt", int'(req), 1);
      check(!urg, "R8", "not urgent at two", int'(urg), 0);
      wait_cyc(t_ready + 5 * IVL + 50);
      check(debt == 5 && urg, "R8", "urgent at five", int'(debt), 5);
      wait_cyc(t_ready + 12 * IVL + 50);
      check(debt == DMAX, "R8", "saturated debt", int'(debt), DMAX);

      // drain on grant
      gnt = 1'b1;
      for (int i = 0; i < 400 && debt != 0; i++) step();
      step();
      check(debt == 0 && !req, "R9", "drained debt drops request", int'(debt), 0);

      // random grants, ticks and completions collide
      for (int i = 0; i < 3000; i++) begin
         int mode;
         mode = (i / 250) % 3;
         if (mode == 0)      gnt = ($urandom % 4) == 0;
         else if (mode == 1) gnt = ($urandom % 16) == 0;
         else                gnt = 1'b0;
         step();
      end

      // short self-refresh request
      gnt = 1'b1;
      sreq = 1'b1;
      while (!sref) step();
      repeat (20) step();
      sreq = 1'b0;
      gnt = 1'b0;
      while (sref) step();
      check(self_len >= RASSC, "R11", "minimum self-refresh width", self_len, RASSC);
      check(debt == 0, "R12", "debt cleared on exit", int'(debt), 0);
      wait_cyc(t_exit + IVL - 1);
      check(debt == 0, "R7", "no tick before interval after exit", int'(debt), 0);
      step();
      check(debt == 1, "R7", "tick one interval after exit", int'(debt), 1);

      // long self-refresh request
      gnt = 1'b1;
      sreq = 1'b1;
      while (!sref) step();
      repeat (400) step();
      check(!ras_n && sref, "R11", "RAS held while requested", int'(ras_n), 0);
      sreq = 1'b0;
      while (sref) step();
      check(self_len >= 400, "R11", "self width follows request", self_len, 400);
      for (int i = 0; i < 500; i++) begin
         gnt = ($urandom % 3) == 0;
         step();
      end

      check(v_r4 == 0 && n_ras_fall > 0, "R4", "CBR order violations", v_r4, 0);
      check(v_r5 == 0, "R5", "width/precharge violations", v_r5, 0);
      check(v_r6 == 0, "R6", "WE low cycles", v_r6, 0);
      check(v_r10 == 0, "R10", "strobes without ownership", v_r10, 0);
      check(v_r12 == 0, "R12", "short exit precharge", v_r12, 0);
      check(rdy, "R3", "ready still high", int'(rdy), 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule